// File: doc/BRIEF.md
# Sector ID Record Sequencer

This block supplies the sector identification record that a disk controller hands back, one byte at a time, when software issues a read-address command. The host side sees a data register: each read of that register while a read-address command is active pops the next byte of a six-byte record. The record is assembled on the fly from the controller's current track, side and sector values, a fixed sector-size code, and two check bytes.

The record order is track, side, sector, size code, then the check bytes, high byte first. A `CRC_EN` parameter picks what the check bytes hold. With `CRC_EN` at 0 they read as zero. With it at 1 they carry a CRC-16 computed over the first four bytes. A start strobe, raised whenever the controller begins any command, sends the byte pointer back to the first byte. After the sixth byte the pointer wraps, so the record can be read again from the start.

Top module: `id_record_seq`

## Requirements
- R1: On successive active reads the bytes are track, side (value 0 or 1 in bit 0, upper bits zero), sector, size code, check high, check low. The pointer runs from 0 to 5 in that order.
- R2: The byte at pointer 3 is the size code, 2 by default (512-byte sectors).
- R3: With CRC_EN = 0, both check bytes (pointers 4 and 5) read as 0x00.
- R4: An active read at pointer 5 sets the pointer back to 0, so the seventh read returns the track byte again.
- R5: A cycle with cmd_start high leaves the pointer at 0 on the next cycle.
- R6: A read strobe while cmd_rdaddr is low changes nothing: the pointer and id_byte hold their values and byte_vld stays low.
- R7: With CRC_EN = 1, the check bytes hold a CRC-16 over track, side, sector and size code, taken in that order. It uses polynomial 0x1021, preset 0xFFFF, MSB first, with no reflection and no final XOR. The high byte comes at pointer 4 and the low byte at pointer 5.
- R8: id_byte is registered. It takes the new byte on the clock edge that samples an active read strobe, and byte_vld is high for exactly the following cycle.
- R9: When cmd_start and an active read strobe fall in the same cycle, the start wins. The pointer goes to 0, id_byte holds its value and byte_vld stays low.
- R10: After reset the pointer is 0, id_byte is 0x00 and byte_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle strobe when any new command begins |
| cmd_rdaddr | input | 1 | High while the active command is read address |
| rd_strobe | input | 1 | One-cycle strobe for a data-register read |
| trk_in | input | 8 | Current track value |
| side_in | input | 1 | Current side |
| sec_in | input | 8 | Current sector value |
| id_byte | output | 8 | Last ID byte delivered |
| byte_vld | output | 1 | High the cycle after a byte was delivered |
| id_ptr | output | 3 | Index of the next byte to deliver |

## Verification
A command start and an active data-register read can land in the same cycle. Each one alone would move the pointer differently: the read would advance it and load a byte, while the start would clear it. The bench provokes the collision in the middle of a record, with the pointer away from 0, so that both outcomes can be told apart. It then judges the result at the ports: the pointer must read 0, id_byte must still hold the previous byte, and byte_vld must stay low. A following read must return the track byte.

// File: rtl/id_seq_pkg.sv
package id_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int REC_LEN = 6;
  localparam int PTR_W   = $clog2(REC_LEN);

  typedef logic [BYTE_W-1:0] id_byte_t;

  // one byte into a CRC-16 (poly 0x1021), MSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input id_byte_t d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] crc16_id(input id_byte_t t, input id_byte_t s,
                                           input id_byte_t c, input id_byte_t z);
    logic [15:0] acc;
    acc = 16'hFFFF;
    acc = crc16_byte(acc, t);
    acc = crc16_byte(acc, s);
    acc = crc16_byte(acc, c);
    acc = crc16_byte(acc, z);
    return acc;
  endfunction
endpackage

// File: rtl/id_ptr_ctr.sv
module id_ptr_ctr
  import id_seq_pkg::*;
#(
  parameter int LEN = REC_LEN,
  localparam int PW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          wrap_evt
);
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  assign wrap_evt = adv && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (clr)      ptr <= '0;
    else if (wrap_evt) ptr <= '0;
    else if (adv)      ptr <= ptr + 1'b1;
  end

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) ptr <= LAST);
  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr == LAST) |=> ptr == '0);
  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> ptr == '0);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/id_check_gen.sv
module id_check_gen
  import id_seq_pkg::*;
#(
  parameter bit CRC_EN = 1'b0
) (
  input  id_byte_t    trk,
  input  id_byte_t    sid,
  input  id_byte_t    sec,
  input  id_byte_t    szc,
  output logic [15:0] chk
);
  generate
    if (CRC_EN) begin : g_crc
      assign chk = crc16_id(trk, sid, sec, szc);
    end else begin : g_zero
      assign chk = 16'h0000;
    end
  endgenerate
endmodule

// File: rtl/id_byte_mux.sv
module id_byte_mux
  import id_seq_pkg::*;
(
  input  logic [PTR_W-1:0] sel,
  input  id_byte_t         trk,
  input  id_byte_t         sid,
  input  id_byte_t         sec,
  input  id_byte_t         szc,
  input  logic [15:0]      chk,
  output id_byte_t         dout
);
  always_comb begin
    case (sel)
      3'd0:    dout = trk;
      3'd1:    dout = sid;
      3'd2:    dout = sec;
      3'd3:    dout = szc;
      3'd4:    dout = chk[15:8];
      3'd5:    dout = chk[7:0];
      default: dout = '0;
    endcase
  end
endmodule

// File: rtl/id_record_seq.sv
module id_record_seq
  import id_seq_pkg::*;
#(
  parameter bit       CRC_EN    = 1'b0,
  parameter id_byte_t SIZE_CODE = 8'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_rdaddr,
  input  logic             rd_strobe,
  input  logic [7:0]       trk_in,
  input  logic             side_in,
  input  logic [7:0]       sec_in,
  output logic [7:0]       id_byte,
  output logic             byte_vld,
  output logic [PTR_W-1:0] id_ptr
);
  // named internal events
  logic        adv_evt;
  logic        wrap_evt;
  logic        clash_evt;
  id_byte_t    side_byte;
  id_byte_t    next_byte;
  logic [15:0] chk_word;

  assign adv_evt   = rd_strobe && cmd_rdaddr && !cmd_start;
  assign clash_evt = rd_strobe && cmd_rdaddr && cmd_start;
  assign side_byte = {{(BYTE_W-1){1'b0}}, side_in};

  id_ptr_ctr #(.LEN(REC_LEN)) ptr_i (
    .clk(clk), .rst_n(rst_n), .clr(cmd_start), .adv(adv_evt),
    .ptr(id_ptr), .wrap_evt(wrap_evt)
  );

  id_check_gen #(.CRC_EN(CRC_EN)) chk_i (
    .trk(trk_in), .sid(side_byte), .sec(sec_in), .szc(SIZE_CODE), .chk(chk_word)
  );

  id_byte_mux mux_i (
    .sel(id_ptr), .trk(trk_in), .sid(side_byte), .sec(sec_in), .szc(SIZE_CODE),
    .chk(chk_word), .dout(next_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_byte  <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= adv_evt;
      if (adv_evt) id_byte <= next_byte;
    end
  end

  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) adv_evt |=> byte_vld);
  // R2
  size_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && id_ptr == 3'd3) |=> id_byte == SIZE_CODE);
  // R9
  clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_evt |=> ($stable(id_byte) && !byte_vld && id_ptr == '0));
  // R4
  wrap_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> id_ptr == '0);
endmodule

// File: tb/id_record_seq_tb_top.sv
module id_record_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_rdaddr = 1'b0, rd_strobe = 1'b0;
  logic [7:0] trk_in = '0, sec_in = '0;
  logic side_in = 1'b0;
  logic [7:0] byte_a, byte_b;
  logic vld_a, vld_b;
  logic [2:0] ptr_a, ptr_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  id_record_seq #(.CRC_EN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rdaddr(cmd_rdaddr),
    .rd_strobe(rd_strobe), .trk_in(trk_in), .side_in(side_in), .sec_in(sec_in),
    .id_byte(byte_a), .byte_vld(vld_a), .id_ptr(ptr_a));

  id_record_seq #(.CRC_EN(1'b1)) dut_crc_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rdaddr(cmd_rdaddr),
    .rd_strobe(rd_strobe), .trk_in(trk_in), .side_in(side_in), .sec_in(sec_in),
    .id_byte(byte_b), .byte_vld(vld_b), .id_ptr(ptr_b));

  // vectors: {track, side, sector}
  localparam logic [16:0] VEC [4] = '{
    {8'd0,   1'b0, 8'd1},
    {8'd79,  1'b1, 8'd9},
    {8'd40,  1'b0, 8'd5},
    {8'hA5,  1'b1, 8'hFF}
  };

  // bitwise CRC, feedback form
  function automatic logic [15:0] ref_crc(input logic [31:0] msg);
    logic [15:0] c = 16'hFFFF;
    for (int b = 31; b >= 0; b--) begin
      logic fb = c[15] ^ msg[b];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] exp_byte(input int idx, input bit crc);
    logic [15:0] k = crc ? ref_crc({trk_in, 7'd0, side_in, sec_in, 8'd2}) : 16'h0;
    case (idx)
      0: return trk_in;
      1: return {7'd0, side_in};
      2: return sec_in;
      3: return 8'd2;
      4: return k[15:8];
      default: return k[7:0];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input bit rdaddr);
    cmd_start = 1'b1; cmd_rdaddr = rdaddr;
    @(posedge clk); @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic read_once();
    rd_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic read_and_check(input int idx, input string req);
    logic [7:0] ea = exp_byte(idx, 1'b0);
    logic [7:0] eb = exp_byte(idx, 1'b1);
    read_once();
    check(byte_a == ea && vld_a, req, byte_a, ea);
    check(byte_b == eb && vld_b, {req, "/R7"}, byte_b, eb);
  endtask

  initial begin
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(ptr_a == 0 && byte_a == 0 && vld_a == 0, "R10", {ptr_a, byte_a, vld_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R7 R4 R8
    foreach (VEC[v]) begin
      {trk_in, side_in, sec_in} = VEC[v];
      start_cmd(1'b1);
      check(ptr_a == 0, "R5", ptr_a, 0);
      for (int i = 0; i < 6; i++) begin
        read_and_check(i, i == 3 ? "R2" : (i >= 4 ? "R3" : "R1"));
      end
      check(ptr_a == 0, "R4 wrap", ptr_a, 0);
      read_and_check(0, "R4 seventh");
      @(negedge clk);
      check(vld_a == 0, "R8 single pulse", vld_a, 0);
    end

    // R6: inactive reads change nothing
    {trk_in, side_in, sec_in} = VEC[1];
    start_cmd(1'b1);
    read_and_check(0, "R1");
    read_and_check(1, "R1");
    hold = byte_a;
    start_cmd(1'b0);
    read_once();
    check(ptr_a == 0 && byte_a == hold && !vld_a, "R6", {ptr_a, byte_a}, {3'd0, hold});
    cmd_rdaddr = 1'b1;
    read_and_check(0, "R6 resume");
    read_and_check(1, "R6 resume");
    cmd_rdaddr = 1'b0;
    read_once();
    check(ptr_a == 2 && byte_a == exp_byte(1, 0) && !vld_a, "R6 mid", ptr_a, 2);
    cmd_rdaddr = 1'b1;
    read_and_check(2, "R6 continue");

    // R5: start mid-record
    start_cmd(1'b1);
    check(ptr_a == 0, "R5 mid", ptr_a, 0);
    read_and_check(0, "R5 restart");
    read_and_check(1, "R1");

    // R9: start and read in same cycle
    hold = byte_a;
    cmd_start = 1'b1; rd_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_start = 1'b0; rd_strobe = 1'b0;
    check(ptr_a == 0 && byte_a == hold && !vld_a, "R9", {ptr_a, byte_a, vld_a}, {3'd0, hold, 1'b0});
    read_and_check(0, "R9 after");

    // R10: reset mid-record
    rst_n = 1'b0;
    @(negedge clk);
    check(ptr_a == 0 && byte_a == 0 && !vld_a, "R10 again", {ptr_a, byte_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule